// File: doc/BRIEF.md
# Coast Window Generator for a Line-Locked Clock

This block drives the hold request of a clock generator that locks to horizontal sync. While the hold request is active, the clock generator ignores horizontal sync edges and keeps its nominal frequency. This lets it ride through the vertical interval, where the equalisation and serration pulses would otherwise disturb the lock.

The window can start a programmed number of lines before vertical sync. Because vertical sync has not yet arrived at that point, the block counts horizontal sync rising edges between successive vertical sync leading edges. It then uses the total from the previous frame to predict where the next vertical sync will land. The window can also stay open for a programmed number of lines after vertical sync ends. A polarity input selects whether the hold request is driven active high or active low.

Sync inputs are asynchronous levels. Each passes through two flops, and edges are detected on the synchronised copies. The hold request leaves the block from a register.

Top module: `coast_window_gen`

## Requirements
- R1: While reset is asserted and just after its release, the hold request is inactive. With `active_high` = 1 that means `coast_out` = 0.
- R2: With both line counts at 0 and a measured frame, the hold request is active exactly while vertical sync is high (vertical sync is active high), delayed by the fixed latency.
- R3: When vertical sync falls, the hold request stays active until `post_lines` further horizontal sync rising edges have been seen. It goes inactive on the edge that brings that remaining count to 0.
- R4: Once a frame length N has been measured, and `pre_lines` = P with 0 < P < N, the hold request turns active when the count of horizontal sync rising edges since the last vertical sync leading edge reaches N − P. It stays active until vertical sync starts.
- R5: Until two vertical sync leading edges have been seen (one complete frame measured), the pre-window is suppressed. The hold request then covers only vertical sync plus the post-window.
- R6: If P ≥ N, the pre-window begins at line 0 of the frame, so the hold request stays active for the whole frame.
- R7: With `active_high` = 0, `coast_out` is the inverse of the active-high hold request. The polarity input acts on the output without extra delay.
- R8: Every change of the hold request appears three clock edges after the sync input change that caused it: two synchroniser flops plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync level, rising edge marks a line |
| vsync_in | input | 1 | Vertical sync level, active high |
| pre_lines | input | CNT_W | Lines of hold request before vertical sync |
| post_lines | input | CNT_W | Lines of hold request after vertical sync ends |
| active_high | input | 1 | 1: hold request active high, 0: active low |
| coast_out | output | 1 | Hold request to the clock generator |

## Verification
Every sync input event changes the hold request exactly three clock edges after the edge that first samples it. Each time the driver changes `hsync_in` or `vsync_in`, it therefore computes the expected level from a line-level model of the requirements. It queues that level tagged with the cycle that is three edges later. The monitor compares the output only on falling clock edges in that tagged cycle. Line counts and polarity are changed only while vertical sync holds the window open, so a change never lands between an event and its scheduled check.

// File: rtl/coast_window_gen.sv
module coast_window_gen #(
  parameter int CNT_W  = 8,
  parameter int LINE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [CNT_W-1:0] pre_lines,
  input  logic [CNT_W-1:0] post_lines,
  input  logic             active_high,
  output logic             coast_out
);

  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic hs_s1, hs_s2, vs_s1, vs_s2;
  logic hs_rise, vs_rise, vs_fall;
  logic [LINE_W-1:0] line_cnt, frame_len, pre_ext, pre_start;
  logic [CNT_W-1:0]  post_cnt;
  logic seen_vs, frame_ok;
  logic pre_on, coast_act, coast_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_s1 <= 1'b0;
      hs_s2 <= 1'b0;
      vs_s1 <= 1'b0;
      vs_s2 <= 1'b0;
    end else begin
      hs_s1 <= hsync_in;
      hs_s2 <= hs_s1;
      vs_s1 <= vsync_in;
      vs_s2 <= vs_s1;
    end
  end

  assign hs_rise = hs_s1 & ~hs_s2;
  assign vs_rise = vs_s1 & ~vs_s2;
  assign vs_fall = ~vs_s1 & vs_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      frame_len <= '0;
      seen_vs   <= 1'b0;
      frame_ok  <= 1'b0;
    end else if (vs_rise) begin
      line_cnt  <= '0;
      frame_len <= line_cnt;
      seen_vs   <= 1'b1;
      frame_ok  <= seen_vs;
    end else if (hs_rise && line_cnt != LINE_MAX) begin
      line_cnt  <= line_cnt + 1'b1;
    end
  end

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_cnt == '0));  // R4

  always_ff @(posedge clk) begin
    if (!rst_n)
      post_cnt <= '0;
    else if (vs_fall)
      post_cnt <= post_lines;
    else if (hs_rise && post_cnt != '0)
      post_cnt <= post_cnt - 1'b1;
  end

  AST_POST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    vs_fall |=> (post_cnt == $past(post_lines)));  // R3

  assign pre_ext   = LINE_W'(pre_lines);
  assign pre_start = (pre_ext >= frame_len) ? '0 : frame_len - pre_ext;
  assign pre_on    = frame_ok && (pre_lines != '0) && (line_cnt >= pre_start);
  assign coast_act = vs_s2 | (post_cnt != '0) | pre_on;

  always_ff @(posedge clk) begin
    if (!rst_n)
      coast_q <= 1'b0;
    else
      coast_q <= coast_act;
  end

  assign coast_out = active_high ? coast_q : ~coast_q;

  AST_VS_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    vs_s2 |=> coast_q);  // R2

  AST_POST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (post_cnt != '0) |=> coast_q);  // R3

  AST_NO_PRE_UNMEASURED: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_ok && !vs_s2 && post_cnt == '0) |=> !coast_q);  // R5

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vs_s1) && vs_s1) |=> ##1 coast_q);  // R8

endmodule

// File: tb/coast_window_gen_tb.sv
module coast_window_gen_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, active_high = 1'b1;
  logic [7:0] pre_lines = 8'd2, post_lines = 8'd1;
  logic coast_out;

  always #2.5 clk = ~clk;

  coast_window_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .pre_lines(pre_lines), .post_lines(post_lines),
    .active_high(active_high), .coast_out(coast_out)
  );

  typedef struct {
    int    at;
    bit    exp;
    bit    pol;
    string tag;
  } item_t;

  item_t sb_q[$];
  int cyc = 0, compared = 0, mismatched = 0;
  bit done = 1'b0;

  int lc = 0, nmeas = 0, prem = 0;
  bit seen = 0, valid = 0, vsh = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void push_exp();
    item_t it;
    int start;
    bit pre_on;
    start  = (int'(pre_lines) >= nmeas) ? 0 : nmeas - int'(pre_lines);
    pre_on = valid && pre_lines != 0 && lc >= start;
    it.at  = cyc + 3;
    it.pol = active_high;
    it.exp = vsh || prem > 0 || pre_on;
    if (vsh)                               it.tag = "R2";
    else if (prem > 0)                     it.tag = "R3";
    else if (pre_on && int'(pre_lines) >= nmeas) it.tag = "R6";
    else if (pre_on)                       it.tag = "R4";
    else if (!valid)                       it.tag = "R5";
    else                                   it.tag = "R2";
    if (!active_high) it.tag = {it.tag, "/R7"};
    it.tag = {it.tag, "/R8"};
    sb_q.push_back(it);
  endfunction

  task automatic line(int vev);
    @(negedge clk);
    hsync_in = 1'b1;
    lc++;
    if (prem > 0) prem--;
    push_exp();
    repeat (2) @(negedge clk);
    hsync_in = 1'b0;
    push_exp();
    repeat (2) @(negedge clk);
    if (vev == 1) begin
      vsync_in = 1'b1;
      vsh = 1;
      if (seen) begin nmeas = lc; valid = 1; end
      seen = 1;
      lc = 0;
      push_exp();
    end else if (vev == 2) begin
      vsync_in = 1'b0;
      vsh = 0;
      prem = int'(post_lines);
      push_exp();
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(int nl, int vl, int pre, int post, bit pol);
    for (int k = 0; k < nl; k++) begin
      if (k == 1) begin
        @(negedge clk);
        pre_lines   = 8'(pre);
        post_lines  = 8'(post);
        active_high = pol;
        push_exp();
      end
      line(k == 0 ? 1 : (k == vl ? 2 : 0));
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #0.5;
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
        item_t it;
        bit want;
        it = sb_q.pop_front();
        want = it.pol ? it.exp : ~it.exp;
        compared++;
        if (it.at != cyc || coast_out !== want) begin
          mismatched++;
          $display("FAIL %s cycle %0d: coast_out=%b expected %b", it.tag, cyc, coast_out, want);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    compared++;  // R1: idle during reset
    if (coast_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 in reset: coast_out=%b expected 0", coast_out);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compared++;  // R1: idle after release
    if (coast_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 after reset: coast_out=%b expected 0", coast_out);
    end
    for (int i = 0; i < 3; i++) line(0);
    frame(10, 2, 2, 1, 1'b1);   // R5: unmeasured, pre suppressed
    frame(10, 2, 2, 1, 1'b1);   // R4: pre window at lines 8,9
    frame(10, 2, 0, 0, 1'b1);   // R2: window equals vsync
    frame(10, 3, 20, 3, 1'b1);  // R6: pre beyond frame length
    frame(10, 2, 3, 2, 1'b0);   // R7: active-low output
    frame(10, 2, 0, 0, 1'b1);   // R2
    line(0);
    repeat (6) @(negedge clk);
    if (sb_q.size() != 0) begin
      mismatched++;
      $display("FAIL R8 %0d results never compared: actual %0d expected 0", sb_q.size(), sb_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : watchdog
    wait (cyc >= 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL R8 watchdog expired: actual cycle %0d expected end before 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule